// File: doc/BRIEF.md
# Banked Memory Window Extender

This block lets a processor with a 16-bit address bus and an 8-bit data bus reach a 256K-byte physical memory. The lower half of the processor's address space is a 32K-byte window into memory. The upper half holds a bank-select register. The processor changes banks with an ordinary store: it writes a bank number to any address whose top bit is set, and later accesses to the window use that bank.

Each window access passes to memory combinationally. The 18-bit physical address is the 3-bit bank number placed above the 15 offset bits of the processor address. Register accesses never drive the memory enable. The processor side uses plain read and write strobes that complete in one cycle, and the memory is expected to return read data in the same cycle. Neither side stalls, so the block has no valid/ready handshake and no back-pressure.

Top module: `bank_addr_extender`

## Requirements
- R1: After reset the bank number is 0. A register read returns 0x00, and a window access drives mem_addr[17:15] = 0.
- R2: On a rising clock edge with cpu_wr = 1 and cpu_addr[15] = 1, the bank number loads from cpu_wdata[2:0]. Data bits 7..3 are discarded.
- R3: mem_ce is 1 exactly when cpu_rd or cpu_wr is 1 and cpu_addr[15] = 0.
- R4: A write with cpu_addr[15] = 1 never reaches memory: mem_ce = 0 and mem_we = 0 in that cycle.
- R5: mem_addr is {bank[2:0], cpu_addr[14:0]}, so equal offsets in different banks reach distinct memory bytes.
- R6: A read with cpu_addr[15] = 1 returns the bank number in cpu_rdata[2:0], and cpu_rdata[7:3] = 0.
- R7: A read with cpu_addr[15] = 0 returns mem_rdata on cpu_rdata in the same cycle.
- R8: A window write drives mem_we = 1 and mem_wdata = cpu_wdata. mem_we is never 1 while mem_ce is 0.
- R9: A new bank number is used by the first access after the clock edge that wrote it.
- R10: The bank number holds its value in every cycle without a register write, including cycles with register reads and window accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data to the processor |
| mem_ce | output | 1 | Memory chip enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 18 | Physical memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
Several properties are checked on every cycle. Memory is enabled only inside the window. Register writes are blocked from memory. The window offset is passed through unchanged. A register read returns the live bank number. The bank number changes only on a register write, and then it takes the written low bits.

Some behaviours show only in the bench's scenarios against its sparse memory model. These are: distinct banks reaching distinct bytes, data written in one bank surviving a visit to another bank, discarding of the upper data bits as seen through read-back, and the one-cycle switchover.

// File: rtl/bxt_pkg.sv
package bxt_pkg;
  parameter int unsigned OFFS_W = 15;
  parameter int unsigned BANK_W = 3;
  parameter int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ACC_IDLE   = 3'd0,
    ACC_MEM_RD = 3'd1,
    ACC_MEM_WR = 3'd2,
    ACC_REG_RD = 3'd3,
    ACC_REG_WR = 3'd4
  } acc_kind_e;
endpackage

// File: rtl/bxt_decode.sv
module bxt_decode
  import bxt_pkg::*;
(
  input  logic      sel_reg,
  input  logic      rd,
  input  logic      wr,
  output acc_kind_e kind
);
  always_comb begin
    kind = ACC_IDLE;
    if (wr)      kind = sel_reg ? ACC_REG_WR : ACC_MEM_WR;
    else if (rd) kind = sel_reg ? ACC_REG_RD : ACC_MEM_RD;
  end
endmodule

// File: rtl/bxt_bank_reg.sv
module bxt_bank_reg #(
  parameter int unsigned BANK_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    bank_q <= '0;
    else if (load) bank_q <= wdata[BANK_W-1:0];
  end
endmodule

// File: rtl/bxt_phys_map.sv
module bxt_phys_map
  import bxt_pkg::*;
#(
  parameter int unsigned OFFS_W = 15,
  parameter int unsigned BANK_W = 3,
  localparam int unsigned PHYS_W = OFFS_W + BANK_W
) (
  input  acc_kind_e         kind,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFFS_W-1:0] offs,
  output logic              ce,
  output logic              we,
  output logic [PHYS_W-1:0] paddr
);
  always_comb begin
    ce    = (kind == ACC_MEM_RD) || (kind == ACC_MEM_WR);
    we    = (kind == ACC_MEM_WR);
    paddr = {bank, offs};
  end
endmodule

// File: rtl/bxt_rdata_mux.sv
module bxt_rdata_mux
  import bxt_pkg::*;
#(
  parameter int unsigned BANK_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  acc_kind_e         kind,
  input  logic [BANK_W-1:0] bank,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] bank_ext;

  generate
    if (DATA_W > BANK_W) begin : g_pad
      assign bank_ext = {{(DATA_W-BANK_W){1'b0}}, bank};
    end else begin : g_trunc
      assign bank_ext = bank[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (kind)
      ACC_MEM_RD: rdata = mem_rdata;
      ACC_REG_RD: rdata = bank_ext;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/bank_addr_extender.sv
module bank_addr_extender
  import bxt_pkg::*;
#(
  parameter int unsigned P_OFFS_W = bxt_pkg::OFFS_W,
  parameter int unsigned P_BANK_W = bxt_pkg::BANK_W,
  parameter int unsigned P_DATA_W = bxt_pkg::DATA_W,
  localparam int unsigned CPU_AW = P_OFFS_W + 1,
  localparam int unsigned PHYS_W = P_OFFS_W + P_BANK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic [P_DATA_W-1:0] cpu_wdata,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  output logic [P_DATA_W-1:0] cpu_rdata,
  output logic                mem_ce,
  output logic                mem_we,
  output logic [PHYS_W-1:0]   mem_addr,
  output logic [P_DATA_W-1:0] mem_wdata,
  input  logic [P_DATA_W-1:0] mem_rdata
);
  acc_kind_e           kind;
  logic [P_BANK_W-1:0] bank_q;
  logic                bank_load;

  bxt_decode u_decode (
    .sel_reg (cpu_addr[CPU_AW-1]),
    .rd      (cpu_rd),
    .wr      (cpu_wr),
    .kind    (kind)
  );

  assign bank_load = (kind == ACC_REG_WR);

  bxt_bank_reg #(.BANK_W(P_BANK_W), .DATA_W(P_DATA_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (bank_load),
    .wdata  (cpu_wdata),
    .bank_q (bank_q)
  );

  bxt_phys_map #(.OFFS_W(P_OFFS_W), .BANK_W(P_BANK_W)) u_map (
    .kind  (kind),
    .bank  (bank_q),
    .offs  (cpu_addr[P_OFFS_W-1:0]),
    .ce    (mem_ce),
    .we    (mem_we),
    .paddr (mem_addr)
  );

  bxt_rdata_mux #(.BANK_W(P_BANK_W), .DATA_W(P_DATA_W)) u_rmux (
    .kind      (kind),
    .bank      (bank_q),
    .mem_rdata (mem_rdata),
    .rdata     (cpu_rdata)
  );

  assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/bxt_checker.sv
module bxt_checker #(
  parameter int unsigned OFFS_W = 15,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [OFFS_W:0]          cpu_addr,
  input logic [DATA_W-1:0]        cpu_wdata,
  input logic                     cpu_rd,
  input logic                     cpu_wr,
  input logic [DATA_W-1:0]        cpu_rdata,
  input logic                     mem_ce,
  input logic                     mem_we,
  input logic [OFFS_W+BANK_W-1:0] mem_addr,
  input logic [BANK_W-1:0]        bank
);
  AST_CE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce |-> (!cpu_addr[OFFS_W] && (cpu_rd || cpu_wr))); // R3
  AST_REG_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[OFFS_W]) |-> (!mem_ce && !mem_we)); // R4
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce |-> (mem_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0])); // R5
  AST_BANK_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce |-> (mem_addr[OFFS_W+BANK_W-1:OFFS_W] == bank)); // R9
  AST_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && cpu_addr[OFFS_W]) |-> (cpu_rdata == DATA_W'(bank))); // R6
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_ce); // R8
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[OFFS_W]) |=> (bank == $past(cpu_wdata[BANK_W-1:0]))); // R2
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[OFFS_W]) |=> $stable(bank)); // R10
endmodule

bind bank_addr_extender bxt_checker #(
  .OFFS_W(P_OFFS_W), .BANK_W(P_BANK_W), .DATA_W(P_DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
  .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr), .bank(bank_q)
);

// File: tb/bank_addr_extender_bench.sv
module bank_addr_extender_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        mem_ce, mem_we;
  logic [17:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int wr_tick = 0;
  logic [7:0] store [int];
  logic [2:0] exp_bank = 3'd0;

  always #4 clk = ~clk;

  bank_addr_extender u_bank_addr_extender (.*);

  function automatic logic [7:0] seed(input logic [17:0] a);
    return a[7:0] ^ {a[17:15], a[12:8]};
  endfunction

  always @(posedge clk) begin
    if (mem_ce && mem_we) begin
      store[int'(mem_addr)] = mem_wdata;
      wr_tick = wr_tick + 1;
    end
  end

  always @(mem_addr, wr_tick) begin
    if (store.exists(int'(mem_addr))) mem_rdata = store[int'(mem_addr)];
    else mem_rdata = seed(mem_addr);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive at negedge, settle, leave signals in place until next call
  task automatic bus(input logic rd, input logic wr, input logic [15:0] a,
                     input logic [7:0] d);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    #1;
  endtask

  task automatic idle();
    bus(1'b0, 1'b0, 16'h0000, 8'h00);
  endtask

  task automatic set_bank(input logic [7:0] d);
    bus(1'b0, 1'b1, 16'h8000 | 16'(d) << 4, d);
    exp_bank = d[2:0];
  endtask

  task automatic t_reset();
    bus(1'b1, 1'b0, 16'hC123, 8'h00);
    chk("R1 reg read after reset", cpu_rdata, 8'h00);
    bus(1'b1, 1'b0, 16'h1234, 8'h00);
    chk("R1 bank bits after reset", mem_addr[17:15], 0);
    chk("R7 window read data", cpu_rdata, seed({3'd0, 15'h1234}));
  endtask

  task automatic t_bank_load();
    set_bank(8'hFD);
    chk("R4 reg write ce", mem_ce, 0);
    chk("R4 reg write we", mem_we, 0);
    bus(1'b1, 1'b0, 16'hFFFF, 8'h00);
    chk("R2 upper bits dropped", cpu_rdata, 8'h05);
    chk("R6 reg read upper zero", cpu_rdata[7:3], 0);
    chk("R3 no ce on reg read", mem_ce, 0);
  endtask

  task automatic t_all_banks();
    for (int b = 0; b < 8; b++) begin
      set_bank(8'(b));
      bus(1'b1, 1'b0, 16'h7ABC, 8'h00);
      chk("R5 phys addr", mem_addr, {3'(b), 15'h7ABC});
      chk("R3 ce on window read", mem_ce, 1);
      chk("R7 read data", cpu_rdata, seed({3'(b), 15'h7ABC}));
    end
  endtask

  task automatic t_isolation();
    for (int b = 0; b < 8; b++) begin
      set_bank(8'(b));
      bus(1'b0, 1'b1, 16'h0042, 8'(8'hA0 + b));
      chk("R8 mem we", mem_we, 1);
      chk("R8 mem wdata", mem_wdata, 8'hA0 + b);
    end
    for (int b = 7; b >= 0; b--) begin
      set_bank(8'(b));
      bus(1'b1, 1'b0, 16'h0042, 8'h00);
      chk("R5 banks distinct", cpu_rdata, 8'hA0 + b);
    end
  endtask

  task automatic t_reg_write_no_mem();
    set_bank(8'h02);
    bus(1'b1, 1'b0, 16'h0300, 8'h00);
    chk("R4 pre value", cpu_rdata, seed({3'd2, 15'h0300}));
    bus(1'b0, 1'b1, 16'h8300, 8'h02);
    chk("R4 ce during reg write", mem_ce, 0);
    bus(1'b1, 1'b0, 16'h0300, 8'h00);
    chk("R4 memory unchanged", cpu_rdata, seed({3'd2, 15'h0300}));
  endtask

  task automatic t_hold();
    set_bank(8'h06);
    bus(1'b1, 1'b0, 16'h9000, 8'h00);
    bus(1'b0, 1'b1, 16'h0010, 8'h11);
    bus(1'b1, 1'b0, 16'h0010, 8'h00);
    idle();
    bus(1'b1, 1'b0, 16'h8001, 8'h00);
    chk("R10 bank held", cpu_rdata, 8'h06);
  endtask

  task automatic t_switchover();
    set_bank(8'h01);
    bus(1'b0, 1'b1, 16'hA000, 8'h03);
    chk("R9 old bank in write cycle", mem_ce, 0);
    bus(1'b1, 1'b0, 16'h0555, 8'h00);
    chk("R9 new bank next access", mem_addr[17:15], 3);
    bus(1'b0, 1'b1, 16'h8000, 8'h04);
    bus(1'b0, 1'b1, 16'h0555, 8'h5A);
    chk("R9 write uses new bank", mem_addr[17:15], 4);
    exp_bank = 3'd4;
  endtask

  task automatic t_reset_again();
    set_bank(8'h07);
    @(negedge clk); rst_n = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_bank = 3'd0;
    bus(1'b1, 1'b0, 16'h8000, 8'h00);
    chk("R1 reset clears bank", cpu_rdata, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bank_load();
    t_all_banks();
    t_isolation();
    t_reg_write_no_mem();
    t_hold();
    t_switchover();
    t_reset_again();
    idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule